// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs whole I2C master transactions on top of a byte-level bus engine. A host sets a target address, an address width, a transaction mode and two buffer lengths, then pulses `start`. The block issues START, STOP, ACK and NACK commands and transmit bytes to the engine, and it reacts to the engine's event pulses. Outgoing data is fetched through a combinational read port indexed by byte position. Incoming data is written out through a write port.

It supports three modes. In a plain write, buffer 0 is sent. In a plain read, buffer 0 is received. In write-then-read, buffer 0 is sent, a repeated start follows, and buffer 1 is received. Both 7-bit and 10-bit addressing are supported. For 10-bit reads, the two-byte header is followed by a repeated start.

On completion the block holds a result code and gives a single-cycle `done` pulse. `busy` covers the whole transaction.

Top module: `i2c_txn_seq`

## Requirements
- R1: Mode encoding on `cfg_mode` is 0 = write, 1 = read, 2 = write-then-read, and 3 behaves as write. With `cfg_ten`=0 the first byte sent, together with `cmd_start`, is {`cfg_addr[6:0]`, rw}. The rw bit is 1 only in read mode.
- R2: With `cfg_ten`=1 the first byte sent with `cmd_start` is {5'b11110, `cfg_addr[9:8]`, 0}. After its ACK, the next byte sent is `cfg_addr[7:0]`.
- R3: In a 10-bit read, after the second address byte is ACKed, the block issues `cmd_start` again with the byte {5'b11110, `cfg_addr[9:8]`, 1}.
- R4: In write-then-read, buffer 0 (which may be empty) is sent. Then a repeated start is issued with the address byte carrying rw = 1, and `cfg_len1` bytes are received.
- R5: A NACK event on any address or data byte sets result 1 (nack) and issues `cmd_stop`. `done` follows only after `ev_stop`.
- R6: When receiving N bytes, each byte except the last is answered with `cmd_ack`. The exception is the byte that brings the count to N-1, which is answered with `cmd_nack`. For N = 1, `cmd_nack` is issued right after the read address is ACKed. At most one command pulse is active in any cycle.
- R7: `ev_arb` ends the transaction with result 2 and `ev_berr` ends it with result 3. This happens in the next cycle, with no STOP. `ev_arb` wins over `ev_berr`, and both win over any other event in the same cycle.
- R8: A start with a zero read length gives result 4 (usage fault) with no bus command. This applies to `cfg_len0` in read mode and to `cfg_len1` in write-then-read.
- R9: An accepted start that is not a usage fault pulses `eng_flush` in the next cycle. This tells the engine to discard a stale received byte and pending events.
- R10: Result codes are 0 = done, 1 = nack, 2 = arbitration lost, 3 = bus error, 4 = usage fault. The result is held until the next start. `done` is a one-cycle pulse one cycle after the terminal state, and `busy` is high from the cycle after start until `done`. After reset, `busy`, `done`, the command outputs and `result` are 0.
- R11: Received bytes beyond the programmed length are never written to the receive port.
- R12: Transmit data is read from `txd_data` at `txd_addr` in ascending index order. Received bytes are written at ascending `rxd_addr` starting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| cfg_addr | input | 10 | Target address |
| cfg_ten | input | 1 | 1 selects 10-bit addressing |
| cfg_mode | input | 2 | Transaction mode |
| cfg_len0 | input | LEN_W | Length of buffer 0 |
| cfg_len1 | input | LEN_W | Length of buffer 1 (read part of write-then-read) |
| cmd_start | output | 1 | Engine command: (repeated) START |
| cmd_stop | output | 1 | Engine command: STOP |
| cmd_ack | output | 1 | Engine command: ACK received byte |
| cmd_nack | output | 1 | Engine command: NACK next received byte |
| eng_flush | output | 1 | Engine command: drop stale data and events |
| tx_valid | output | 1 | Transmit byte valid |
| tx_byte | output | 8 | Transmit byte |
| ev_ack | input | 1 | Engine event: byte ACKed |
| ev_nack | input | 1 | Engine event: byte NACKed |
| ev_rxv | input | 1 | Engine event: received byte valid |
| rx_byte | input | 8 | Received byte |
| ev_stop | input | 1 | Engine event: STOP completed |
| ev_arb | input | 1 | Engine event: arbitration lost |
| ev_berr | input | 1 | Engine event: bus error |
| txd_addr | output | LEN_W | Transmit buffer index |
| txd_data | input | 8 | Transmit buffer data at `txd_addr` |
| rxd_we | output | 1 | Receive buffer write strobe |
| rxd_addr | output | LEN_W | Receive buffer index |
| rxd_data | output | 8 | Receive buffer data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished pulse |
| result | output | 3 | Result code |

## Verification
Every output is registered, so each response is due one cycle after the edge that samples its cause:
- An event answer (command, transmit byte or receive write) appears one cycle after the event.
- `eng_flush` and `busy` appear one cycle after start.
- `result` is set in the cycle after an abort or NACK.
- `done` comes one cycle after that.

The bench's engine model sets its inputs and reads the outputs on the falling edge only. It reacts to what it read there, so every comparison lands one full cycle after the causing edge. Transmit sequences are compared by count and by a position-weighted sum. The receive side is checked by index, by data, and by the receive count at which the first `cmd_nack` appears.

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [9:0]       cfg_addr,
  input  logic             cfg_ten,
  input  logic [1:0]       cfg_mode,
  input  logic [LEN_W-1:0] cfg_len0,
  input  logic [LEN_W-1:0] cfg_len1,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_ack,
  output logic             cmd_nack,
  output logic             eng_flush,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  input  logic             ev_ack,
  input  logic             ev_nack,
  input  logic             ev_rxv,
  input  logic [7:0]       rx_byte,
  input  logic             ev_stop,
  input  logic             ev_arb,
  input  logic             ev_berr,
  output logic [LEN_W-1:0] txd_addr,
  input  logic [7:0]       txd_data,
  output logic             rxd_we,
  output logic [LEN_W-1:0] rxd_addr,
  output logic [7:0]       rxd_data,
  output logic             busy,
  output logic             done,
  output logic [2:0]       result
);

  localparam logic [1:0] MD_READ  = 2'd1;
  localparam logic [1:0] MD_WR_RD = 2'd2;

  localparam logic [2:0] RES_OK    = 3'd0;
  localparam logic [2:0] RES_NACK  = 3'd1;
  localparam logic [2:0] RES_ARB   = 3'd2;
  localparam logic [2:0] RES_BERR  = 3'd3;
  localparam logic [2:0] RES_USAGE = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_WA1, S_WA2, S_RS, S_WRA, S_DSEND, S_WD, S_WRX, S_WSTOP, S_FIN
  } st_t;

  st_t              st;
  logic [9:0]       addr_q;
  logic             ten_q;
  logic [1:0]       mode_q;
  logic [LEN_W-1:0] len0_q, len1_q, idx;

  wire rd_mode = (mode_q == MD_READ);
  wire wr_rd   = (mode_q == MD_WR_RD);
  wire [LEN_W-1:0] rlen = rd_mode ? len0_q : len1_q;
  wire [LEN_W:0]   nidx = {1'b0, idx} + 1'b1;
  wire usage = (cfg_mode == MD_READ && cfg_len0 == '0) ||
               (cfg_mode == MD_WR_RD && cfg_len1 == '0);
  wire waiting_ack = (st == S_WA1) || (st == S_WA2) || (st == S_WRA) || (st == S_WD);

  assign txd_addr = idx;

  function automatic logic [7:0] hdr(input logic rd);
    hdr = ten_q ? {5'b11110, addr_q[9:8], rd} : {addr_q[6:0], rd};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_q <= '0; ten_q <= 1'b0; mode_q <= '0;
      len0_q <= '0; len1_q <= '0; idx <= '0;
      cmd_start <= 1'b0; cmd_stop <= 1'b0; cmd_ack <= 1'b0; cmd_nack <= 1'b0;
      eng_flush <= 1'b0; tx_valid <= 1'b0; tx_byte <= '0;
      rxd_we <= 1'b0; rxd_addr <= '0; rxd_data <= '0;
      busy <= 1'b0; done <= 1'b0; result <= RES_OK;
    end else begin
      cmd_start <= 1'b0; cmd_stop <= 1'b0; cmd_ack <= 1'b0; cmd_nack <= 1'b0;
      eng_flush <= 1'b0; tx_valid <= 1'b0; rxd_we <= 1'b0; done <= 1'b0;
      if (st != S_IDLE && st != S_FIN && (ev_arb || ev_berr)) begin
        result <= ev_arb ? RES_ARB : RES_BERR;
        st <= S_FIN;
      end else if (waiting_ack && ev_nack) begin
        result <= RES_NACK;
        cmd_stop <= 1'b1;
        st <= S_WSTOP;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            addr_q <= cfg_addr; ten_q <= cfg_ten; mode_q <= cfg_mode;
            len0_q <= cfg_len0; len1_q <= cfg_len1; idx <= '0;
            busy <= 1'b1;
            if (usage) begin
              result <= RES_USAGE;
              st <= S_FIN;
            end else begin
              result <= RES_OK;
              eng_flush <= 1'b1;
              st <= S_HDR;
            end
          end
          S_HDR: begin
            cmd_start <= 1'b1;
            tx_valid <= 1'b1;
            tx_byte <= hdr(!ten_q && rd_mode);
            st <= S_WA1;
          end
          S_WA1: if (ev_ack) begin
            if (ten_q) begin
              tx_valid <= 1'b1;
              tx_byte <= addr_q[7:0];
              st <= S_WA2;
            end else if (rd_mode) begin
              idx <= '0;
              cmd_nack <= (rlen == 1);
              st <= S_WRX;
            end else begin
              idx <= '0;
              st <= S_DSEND;
            end
          end
          S_WA2: if (ev_ack) st <= rd_mode ? S_RS : S_DSEND;
          S_RS: begin
            cmd_start <= 1'b1;
            tx_valid <= 1'b1;
            tx_byte <= hdr(1'b1);
            idx <= '0;
            st <= S_WRA;
          end
          S_WRA: if (ev_ack) begin
            cmd_nack <= (rlen == 1);
            st <= S_WRX;
          end
          S_DSEND: begin
            if (idx >= len0_q) begin
              if (wr_rd) st <= S_RS;
              else begin
                cmd_stop <= 1'b1;
                st <= S_WSTOP;
              end
            end else begin
              tx_valid <= 1'b1;
              tx_byte <= txd_data;
              idx <= idx + 1'b1;
              st <= S_WD;
            end
          end
          S_WD: if (ev_ack) st <= S_DSEND;
          S_WRX: if (ev_rxv) begin
            if (idx < rlen) begin
              rxd_we <= 1'b1;
              rxd_addr <= idx;
              rxd_data <= rx_byte;
              idx <= nidx[LEN_W-1:0];
            end
            if (nidx >= {1'b0, rlen}) begin
              cmd_stop <= 1'b1;
              st <= S_WSTOP;
            end else if (nidx == {1'b0, rlen} - 1'b1) begin
              cmd_nack <= 1'b1;
            end else begin
              cmd_ack <= 1'b1;
            end
          end
          S_WSTOP: if (ev_stop) st <= S_FIN;
          S_FIN: begin
            done <= 1'b1;
            busy <= 1'b0;
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_arb_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != S_FIN && ev_arb) |=> (result == RES_ARB && !cmd_stop) ##1 done);
  p_berr_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != S_FIN && ev_berr && !ev_arb) |=> (result == RES_BERR && !cmd_stop));
  p_nack_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting_ack && ev_nack && !ev_arb && !ev_berr) |=> (cmd_stop && result == RES_NACK && !done));
  p_one_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_start, cmd_stop, cmd_ack, cmd_nack}));
  p_usage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && usage) |=> (!eng_flush && !cmd_start) ##1 (done && result == RES_USAGE));
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !usage) |=> (eng_flush && busy));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_rx_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_we |-> (rxd_addr < rlen));

endmodule

// File: tb/i2c_txn_seq_test.sv
`timescale 1ns/1ps
module i2c_txn_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [9:0] cfg_addr = '0;
  logic cfg_ten = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [7:0] cfg_len0 = '0, cfg_len1 = '0;
  logic cmd_start, cmd_stop, cmd_ack, cmd_nack, eng_flush, tx_valid;
  logic [7:0] tx_byte;
  logic ev_ack = 0, ev_nack = 0, ev_rxv = 0, ev_stop = 0, ev_arb = 0, ev_berr = 0;
  logic [7:0] rx_byte = '0;
  logic [7:0] txd_addr, txd_data, rxd_addr, rxd_data;
  logic rxd_we, busy, done;
  logic [2:0] result;

  always #5 clk = ~clk;
  assign txd_data = 8'h30 ^ txd_addr;

  i2c_txn_seq #(.LEN_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr(cfg_addr), .cfg_ten(cfg_ten),
    .cfg_mode(cfg_mode), .cfg_len0(cfg_len0), .cfg_len1(cfg_len1),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_ack(cmd_ack), .cmd_nack(cmd_nack),
    .eng_flush(eng_flush), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .ev_ack(ev_ack), .ev_nack(ev_nack), .ev_rxv(ev_rxv), .rx_byte(rx_byte),
    .ev_stop(ev_stop), .ev_arb(ev_arb), .ev_berr(ev_berr),
    .txd_addr(txd_addr), .txd_data(txd_data),
    .rxd_we(rxd_we), .rxd_addr(rxd_addr), .rxd_data(rxd_data),
    .busy(busy), .done(done), .result(result));

  int checks = 0, errors = 0;
  int tx_n, tx_hash, rx_n, rx_bad, nack_pos, got_res, busy_after, flush_seen, timed_out, done_after;
  int exp_n, exp_hash, exp_lim;

  // {ten, mode, addr, len0, len1, nack_at (FF = none), expected result}
  localparam logic [39:0] VEC [0:11] = '{
    {1'b0, 2'd0, 10'h055, 8'd3, 8'd0, 8'hFF, 3'd0},
    {1'b0, 2'd1, 10'h02A, 8'd4, 8'd0, 8'hFF, 3'd0},
    {1'b0, 2'd1, 10'h071, 8'd1, 8'd0, 8'hFF, 3'd0},
    {1'b0, 2'd2, 10'h013, 8'd2, 8'd3, 8'hFF, 3'd0},
    {1'b1, 2'd0, 10'h2C5, 8'd2, 8'd0, 8'hFF, 3'd0},
    {1'b1, 2'd1, 10'h1A3, 8'd2, 8'd0, 8'hFF, 3'd0},
    {1'b1, 2'd2, 10'h37E, 8'd1, 8'd1, 8'hFF, 3'd0},
    {1'b0, 2'd0, 10'h044, 8'd3, 8'd0, 8'd2,  3'd1},
    {1'b0, 2'd1, 10'h066, 8'd2, 8'd0, 8'd0,  3'd1},
    {1'b0, 2'd2, 10'h019, 8'd0, 8'd2, 8'hFF, 3'd0},
    {1'b0, 2'd1, 10'h022, 8'd0, 8'd5, 8'hFF, 3'd4},
    {1'b0, 2'd2, 10'h033, 8'd2, 8'd0, 8'hFF, 3'd4}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void push(input logic [7:0] b);
    if (exp_n < exp_lim) begin
      exp_hash += int'(b) * (exp_n + 1);
      exp_n++;
    end
  endfunction

  function automatic void build_exp(input bit ten, input logic [1:0] mode, input logic [9:0] a,
                                    input int l0, input int lim);
    bit rd;
    rd = (mode == 2'd1);
    exp_n = 0; exp_hash = 0; exp_lim = lim;
    if (ten) begin
      push({5'b11110, a[9:8], 1'b0});
      push(a[7:0]);
    end else push({a[6:0], rd});
    if (!rd) for (int k = 0; k < l0; k++) push(8'h30 ^ 8'(k));
    if ((ten && rd) || mode == 2'd2) push(ten ? {5'b11110, a[9:8], 1'b1} : {a[6:0], 1'b1});
  endfunction

  task automatic run_txn(input bit ten, input logic [1:0] mode, input logic [9:0] addr,
                         input int l0, input int l1, input int nack_at,
                         input int err_at, input int err_kind, input bit extra_rx);
    int pend_t, pend_ev, rxv_fired;
    bit pend_rd, rx_wait, fin;
    tx_n = 0; tx_hash = 0; rx_n = 0; rx_bad = 0; nack_pos = -1; got_res = 7;
    timed_out = 0; rxv_fired = 0;
    @(negedge clk);
    cfg_ten = ten; cfg_mode = mode; cfg_addr = addr;
    cfg_len0 = 8'(l0); cfg_len1 = 8'(l1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_after = busy;
    flush_seen = eng_flush;
    pend_t = 0; pend_ev = 0; pend_rd = 0; rx_wait = 0; fin = 0;
    for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
      ev_ack = 0; ev_nack = 0; ev_rxv = 0; ev_stop = 0; ev_arb = 0; ev_berr = 0;
      if (done) begin
        got_res = result;
        fin = 1;
      end
      if (tx_valid) begin
        tx_hash += int'(tx_byte) * (tx_n + 1);
        pend_ev = (tx_n == nack_at) ? 2 : 1;
        pend_rd = cmd_start && tx_byte[0] && (tx_n != nack_at);
        pend_t = 2;
        tx_n++;
      end
      if (cmd_nack && nack_pos < 0) nack_pos = rxv_fired;
      if ((cmd_ack || cmd_nack) && rx_wait) begin
        rx_wait = 0; pend_ev = 3; pend_t = 2;
      end
      if (cmd_stop) begin
        rx_wait = 0; pend_ev = 4; pend_t = 3;
        if (extra_rx) begin
          ev_rxv = 1; rx_byte = 8'hEE;
        end
      end
      if (rxd_we) begin
        if (rxd_addr != 8'(rx_n) || rxd_data != 8'hA0 + rxd_addr) rx_bad++;
        rx_n++;
      end
      if (pend_t > 0) begin
        pend_t--;
        if (pend_t == 0) begin
          case (pend_ev)
            1: begin
              ev_ack = 1;
              if (pend_rd) begin pend_ev = 3; pend_t = 3; end
            end
            2: ev_nack = 1;
            3: begin
              ev_rxv = 1; rx_byte = 8'hA0 + 8'(rxv_fired); rxv_fired++; rx_wait = 1;
            end
            4: ev_stop = 1;
            default: ;
          endcase
        end
      end
      if (cyc == err_at) begin
        if (err_kind == 1 || err_kind == 3 || err_kind == 4) ev_arb = 1;
        if (err_kind == 2 || err_kind == 3) ev_berr = 1;
        if (err_kind == 4) ev_ack = 1;
      end
      if (!fin) @(negedge clk);
    end
    ev_ack = 0; ev_nack = 0; ev_rxv = 0; ev_stop = 0; ev_arb = 0; ev_berr = 0;
    if (!fin) timed_out = 1;
    chk(!timed_out, "R10 transaction completes", timed_out, 0);
    @(negedge clk);
    done_after = done;
    chk(done == 1'b0, "R10 done is single pulse", done, 0);
    chk(result == 3'(got_res), "R10 result held", result, got_res);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R10 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && result == 0, "R10 reset state", {busy, done, result}, 0);
    chk({cmd_start, cmd_stop, cmd_ack, cmd_nack, tx_valid, rxd_we} == 0, "R10 reset commands",
        {cmd_start, cmd_stop, cmd_ack, cmd_nack, tx_valid, rxd_we}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      logic [39:0] v;
      bit ten;
      logic [1:0] md;
      logic [9:0] a;
      int l0, l1, nk, er, rlen, lim;
      string tg;
      v = VEC[i];
      ten = v[39]; md = v[38:37]; a = v[36:27];
      l0 = int'(v[26:19]); l1 = int'(v[18:11]);
      nk = (v[10:3] == 8'hFF) ? -1 : int'(v[10:3]);
      er = int'(v[2:0]);
      tg = ten ? ((md == 2'd1) ? "R3" : "R2") : ((md == 2'd2) ? "R4" : "R1");
      run_txn(ten, md, a, l0, l1, nk, -1, 0, 0);
      chk(got_res == er, $sformatf("R10 result vec %0d", i), got_res, er);
      chk(busy_after == 1, $sformatf("R10 busy after start vec %0d", i), busy_after, 1);
      if (er == 4) begin
        chk(tx_n == 0 && flush_seen == 0, $sformatf("R8 no bus activity vec %0d", i), tx_n, 0);
      end else begin
        chk(flush_seen == 1, $sformatf("R9 flush vec %0d", i), flush_seen, 1);
        lim = (nk >= 0) ? nk + 1 : 1000;
        build_exp(ten, md, a, l0, lim);
        chk(tx_n == exp_n, $sformatf("%s tx count vec %0d", tg, i), tx_n, exp_n);
        chk(tx_hash == exp_hash, $sformatf("%s R12 tx bytes vec %0d", tg, i), tx_hash, exp_hash);
        if (er == 1) chk(rx_n == 0, $sformatf("R5 no rx after nack vec %0d", i), rx_n, 0);
        if (er == 0) begin
          rlen = (md == 2'd1) ? l0 : ((md == 2'd2) ? l1 : 0);
          chk(rx_n == rlen && rx_bad == 0, $sformatf("R12 rx writes vec %0d", i), rx_n, rlen);
          chk(nack_pos == ((rlen > 0) ? rlen - 1 : -1), $sformatf("R6 nack position vec %0d", i),
              nack_pos, (rlen > 0) ? rlen - 1 : -1);
        end
      end
    end

    // R7 arbitration lost mid-write
    run_txn(1'b0, 2'd0, 10'h055, 4, 0, -1, 6, 1, 0);
    chk(got_res == 2, "R7 arbitration lost", got_res, 2);
    // R7 bus error
    run_txn(1'b0, 2'd1, 10'h055, 3, 0, -1, 5, 2, 0);
    chk(got_res == 3, "R7 bus error", got_res, 3);
    // R7 both at once: arbitration wins
    run_txn(1'b0, 2'd0, 10'h055, 4, 0, -1, 4, 3, 0);
    chk(got_res == 2, "R7 arb over berr", got_res, 2);
    // R7 arbitration with an ack in the same cycle
    run_txn(1'b0, 2'd0, 10'h055, 4, 0, -1, 2, 4, 0);
    chk(got_res == 2, "R7 arb over ack", got_res, 2);
    chk(tx_n == 1, "R7 no further bytes after abort", tx_n, 1);
    // R11 extra received byte while waiting for stop
    run_txn(1'b0, 2'd1, 10'h05A, 2, 0, -1, -1, 0, 1);
    chk(got_res == 0, "R11 result", got_res, 0);
    chk(rx_n == 2 && rx_bad == 0, "R11 extra byte dropped", rx_n, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule